// File: doc/BRIEF.md
# Aperture Page Table Translator

This block turns bus addresses that land inside a remapping window into 40-bit physical addresses. The window's base and size come from two 32-bit configuration words. A base field scaled by 32 MB places the window, and a 3-bit order picks a power-of-two size starting at 32 MB. A window that is empty, that starts at zero, or that would reach past the 4 GB line is treated as switched off.

For an address inside the window, the block works out the index of its 4 KB page. It looks that index up in a small fully associative cache. On a miss it reads one 32-bit page-table entry from an external table memory, which answers after a fixed latency. The entry carries physical bits 31:12 in its own bits 31:12, physical bits 39:32 in its bits 11:4, and a valid flag in bit 0. The page offset is appended to the rebuilt page address to form the answer.

Only entries with the valid flag set are cached. A flush input empties the cache in one cycle. It also cancels the caching of a fetch that is still in flight. The block serves one request at a time and gives exactly one response per accepted request.

Top module: `apt_xlat`

## Requirements
- R1: While reset is held, and after it is released, rsp_valid and tbl_rd_en are 0 and req_ready is 1.
- R2: The window base is cfg_base[14:0] × 2^25 and the window size is 2^25 << cfg_ctrl[3:1]; the other configuration bits have no effect. An address hits when base ≤ addr < base + size, and its page index (addr − base) >> 12 appears on tbl_rd_idx.
- R3: The window is disabled when cfg_base[14:0] is zero or when base + size exceeds 2^32; a limit of exactly 2^32 is allowed. While disabled, every request gets an error response.
- R4: A request that is outside the window, or that arrives while the window is disabled, is answered in the cycle after acceptance with rsp_err = 1 and rsp_paddr = 0, and causes no table read. Every error response carries rsp_paddr = 0.
- R5: On a cache miss, tbl_rd_en is high for exactly the one cycle after acceptance. tbl_rd_data is sampled RD_LAT cycles after that cycle, and the response appears in cycle A+2+RD_LAT, where A is the acceptance cycle. req_ready is low from A+1 until the response cycle.
- R6: A valid entry e yields rsp_paddr = {e[11:4], e[31:12], addr[11:0]} with rsp_err = 0.
- R7: An entry with e[0] = 0 yields an error response and is not cached, so a repeated request reads the table again.
- R8: A valid fetched entry is cached. A later request to the same page is answered in cycle A+1 from the cache with no table read.
- R9: A flush high in a cycle invalidates every cache entry. A request accepted in that same cycle misses.
- R10: If flush is high in any cycle from A+1 through A+1+RD_LAT of a miss, the fetched entry is still returned but is not cached.
- R11: The cache holds CACHE_N pages. When it is full, a new fill replaces the page filled earliest since the last flush.
- R12: Entry bits 1 (coherent) and 3:2 do not affect the translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | 32 | Window base configuration word |
| cfg_ctrl | input | 32 | Window control word, size order in bits 3:1 |
| flush | input | 1 | Invalidate the translation cache |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Bus address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Response is an error |
| rsp_paddr | output | 40 | Translated physical address |
| tbl_rd_en | output | 1 | Table read strobe |
| tbl_rd_idx | output | 20 | Table entry index |
| tbl_rd_data | input | 32 | Table entry, RD_LAT cycles after the read |

## Verification
The hardest case to reach is a flush that lands inside the short window of an outstanding fetch. The stimulus has to time the flush to the cycle right after acceptance, or to the last wait cycle, and then ask for the same page again to see that it misses. Eviction order is also hard to observe, because it only shows up as hit or miss timing. The bench therefore walks more distinct pages than the cache holds and revisits them in a known order. A random phase then mixes flushes placed at acceptance and mid-fetch with out-of-window addresses and invalid entries.

// File: rtl/apt_pkg.sv
package apt_pkg;

  localparam int PTE_W  = 32;
  localparam int PA_W   = 40;
  localparam int PG_W   = 12;
  localparam int PPG_W  = PA_W - PG_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2
  } xl_state_e;

  // rebuild the physical page number from a table entry
  function automatic logic [PPG_W-1:0] pte_page(input logic [PTE_W-1:0] e);
    return {e[11:4], e[31:12]};
  endfunction

  function automatic logic pte_valid(input logic [PTE_W-1:0] e);
    return e[0];
  endfunction

  // entry encoder for the table filler: valid and coherent both set
  function automatic logic [PTE_W-1:0] pte_make(input logic [PA_W-1:0] pa);
    return {pa[31:12], pa[39:32], 2'b00, 1'b1, 1'b1};
  endfunction

endpackage

// File: rtl/apt_rst_sync.sv
module apt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/apt_decode.sv
module apt_decode #(
  parameter int CFG_W   = 32,
  parameter int BUS_W   = 32,
  parameter int PG_W    = 12,
  parameter int BF_W    = 15,
  parameter int BASE_SH = 25,
  parameter int ORD_LSB = 1,
  parameter int ORD_W   = 3,
  parameter int MIN_SH  = 25,
  localparam int IDX_W  = BUS_W - PG_W
) (
  input  logic [CFG_W-1:0] cfg_base,
  input  logic [CFG_W-1:0] cfg_ctrl,
  input  logic [BUS_W-1:0] addr,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  logic [ORD_W-1:0] ord;
  logic [63:0]      base_w, size_w, lim_w, addr_w, off_w;
  logic             win_en;
  logic             unused_dec;

  always_comb begin
    ord    = cfg_ctrl[ORD_LSB +: ORD_W];
    base_w = 64'(cfg_base[BF_W-1:0]) << BASE_SH;
    size_w = (64'd1 << MIN_SH) << ord;
    lim_w  = base_w + size_w;
    addr_w = 64'(addr);
    win_en = (base_w != 64'd0) && (size_w != 64'd0) &&
             (lim_w <= (64'd1 << BUS_W));
    hit    = win_en && (addr_w >= base_w) && (addr_w < lim_w);
    off_w  = addr_w - base_w;
    idx    = off_w[PG_W +: IDX_W];
  end

  assign unused_dec = ^{cfg_base[CFG_W-1:BF_W], cfg_ctrl[CFG_W-1:ORD_LSB+ORD_W],
                        cfg_ctrl[ORD_LSB-1:0], off_w[63:PG_W+IDX_W], off_w[PG_W-1:0]};

endmodule

// File: rtl/apt_cache.sv
module apt_cache #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 20,
  parameter int DATA_W  = 28,
  localparam int PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data
);

  logic [ENTRIES-1:0] vld_q, vld_d, match;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [DATA_W-1:0]  data_q [ENTRIES];
  logic [PTR_W-1:0]   ptr_q, ptr_d;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_way
    assign match[g] = vld_q[g] && (tag_q[g] == lk_tag);
  end

  always_comb begin
    lk_data = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) lk_data = lk_data | data_q[i];
    end
  end

  assign lk_hit = |match;

  always_comb begin
    vld_d = vld_q;
    ptr_d = ptr_q;
    if (flush) begin
      vld_d = '0;
      ptr_d = '0;
    end else if (fill_en) begin
      vld_d[ptr_q] = 1'b1;
      ptr_d = (ptr_q == PTR_W'(ENTRIES-1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else begin
      vld_q <= vld_d;
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (fill_en && (ptr_q == PTR_W'(i))) begin
        tag_q[i]  <= fill_tag;
        data_q[i] <= fill_data;
      end
    end
  end

endmodule

// File: rtl/apt_xlat.sv
module apt_xlat
  import apt_pkg::*;
#(
  parameter int BUS_W   = 32,
  parameter int CACHE_N = 4,
  parameter int RD_LAT  = 2,
  localparam int IDX_W  = BUS_W - PG_W,
  localparam int CNT_W  = $clog2(RD_LAT + 1) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      cfg_base,
  input  logic [31:0]      cfg_ctrl,
  input  logic             flush,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [BUS_W-1:0] req_addr,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             tbl_rd_en,
  output logic [IDX_W-1:0] tbl_rd_idx,
  input  logic [PTE_W-1:0] tbl_rd_data
);

  logic              rst_in_n;
  xl_state_e         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              drop_q, drop_d;
  logic [IDX_W-1:0]  idx_q;
  logic [PG_W-1:0]   off_q;
  logic              rsp_v_q, rsp_v_d, rsp_err_q, rsp_err_d;
  logic [PA_W-1:0]   rsp_pa_q, rsp_pa_d;
  logic              ld_req, fill_en;
  logic              dec_hit;
  logic [IDX_W-1:0]  dec_idx;
  logic              lk_hit;
  logic [PPG_W-1:0]  lk_data;
  logic              unused_pte;

  apt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_in_n)
  );

  apt_decode #(.CFG_W(32), .BUS_W(BUS_W), .PG_W(PG_W)) u_dec (
    .cfg_base (cfg_base),
    .cfg_ctrl (cfg_ctrl),
    .addr     (req_addr),
    .hit      (dec_hit),
    .idx      (dec_idx)
  );

  apt_cache #(.ENTRIES(CACHE_N), .TAG_W(IDX_W), .DATA_W(PPG_W)) u_cache (
    .clk       (clk),
    .rst_n     (rst_in_n),
    .flush     (flush),
    .lk_tag    (dec_idx),
    .lk_hit    (lk_hit),
    .lk_data   (lk_data),
    .fill_en   (fill_en),
    .fill_tag  (idx_q),
    .fill_data (pte_page(tbl_rd_data))
  );

  // next-state logic
  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    drop_d    = drop_q;
    ld_req    = 1'b0;
    fill_en   = 1'b0;
    rsp_v_d   = 1'b0;
    rsp_err_d = 1'b0;
    rsp_pa_d  = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (!dec_hit) begin
            rsp_v_d   = 1'b1;
            rsp_err_d = 1'b1;
          end else if (lk_hit && !flush) begin
            rsp_v_d  = 1'b1;
            rsp_pa_d = {lk_data, req_addr[PG_W-1:0]};
          end else begin
            ld_req = 1'b1;
            drop_d = 1'b0;
            cnt_d  = '0;
            st_d   = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        st_d  = ST_WAIT;
        cnt_d = CNT_W'(1);
        if (flush) drop_d = 1'b1;
      end
      ST_WAIT: begin
        if (flush) drop_d = 1'b1;
        if (cnt_q == CNT_W'(RD_LAT)) begin
          st_d    = ST_IDLE;
          rsp_v_d = 1'b1;
          if (pte_valid(tbl_rd_data)) begin
            rsp_pa_d = {pte_page(tbl_rd_data), off_q};
            fill_en  = !drop_q && !flush;
          end else begin
            rsp_err_d = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      drop_q    <= 1'b0;
      rsp_v_q   <= 1'b0;
      rsp_err_q <= 1'b0;
      rsp_pa_q  <= '0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      drop_q    <= drop_d;
      rsp_v_q   <= rsp_v_d;
      rsp_err_q <= rsp_err_d;
      rsp_pa_q  <= rsp_pa_d;
    end
  end

  // request capture, enabled on a miss
  always_ff @(posedge clk) begin
    if (ld_req) begin
      idx_q <= dec_idx;
      off_q <= req_addr[PG_W-1:0];
    end
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign tbl_rd_en  = (st_q == ST_FETCH);
  assign tbl_rd_idx = idx_q;
  assign rsp_valid  = rsp_v_q;
  assign rsp_err    = rsp_err_q;
  assign rsp_paddr  = rsp_pa_q;
  assign unused_pte = ^tbl_rd_data[3:1];

endmodule

// File: rtl/apt_xlat_chk.sv
module apt_xlat_chk #(
  parameter int PA_W   = 40,
  parameter int RD_LAT = 2,
  localparam int GAP_W = $clog2(RD_LAT + 2) + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_err,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            tbl_rd_en
);

  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      gap_q <= '0;
    else if (tbl_rd_en)                              gap_q <= GAP_W'(1);
    else if (rsp_valid)                              gap_q <= '0;
    else if (gap_q != '0 && gap_q <= GAP_W'(RD_LAT)) gap_q <= gap_q + 1'b1;
  end

  // R5
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rd_en |=> !tbl_rd_en);

  // R5
  rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rd_en |-> !req_ready);

  // R4
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_paddr == '0));

  // R5
  rd_rsp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && gap_q != '0) |-> (gap_q == GAP_W'(RD_LAT + 1)));

  // R5
  rsp_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_q == GAP_W'(RD_LAT + 1)) |-> rsp_valid);

  // R8
  rsp_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

endmodule

bind apt_xlat apt_xlat_chk #(.PA_W(apt_pkg::PA_W), .RD_LAT(RD_LAT)) u_apt_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_paddr (rsp_paddr),
  .tbl_rd_en (tbl_rd_en)
);

// File: tb/test_apt_xlat.sv
module test_apt_xlat;

  localparam int NE = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cfg_base, cfg_ctrl;
  logic        flush, req_valid;
  logic [31:0] req_addr;
  logic        req_ready, rsp_valid, rsp_err, tbl_rd_en;
  logic [39:0] rsp_paddr;
  logic [19:0] tbl_rd_idx;
  logic [31:0] tbl_rd_data;

  always #2 clk = ~clk;

  apt_xlat i_apt_xlat (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_ctrl(cfg_ctrl),
    .flush(flush), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_paddr(rsp_paddr), .tbl_rd_en(tbl_rd_en), .tbl_rd_idx(tbl_rd_idx),
    .tbl_rd_data(tbl_rd_data)
  );

  int    total = 0;
  int    bad   = 0;
  string cur   = "R1";
  logic [31:0] ovr [int];

  function automatic logic [31:0] tbl_entry(int idx);
    if (ovr.exists(idx)) return ovr[idx];
    return ((32'(idx) * 32'h9E3779B1) ^ 32'h35C0_0A10) | 32'h1;
  endfunction

  // table memory: two-cycle read latency
  logic        p1_v;
  logic [19:0] p1_a;
  always @(posedge clk) begin
    p1_v <= tbl_rd_en;
    p1_a <= tbl_rd_idx;
    tbl_rd_data <= p1_v ? tbl_entry(int'(p1_a)) : 32'hDEAD_BEE0;
  end

  task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur, what, act, exp);
    end
  endtask

  // window lookup from the requirements
  function automatic void win(input logic [31:0] a, output bit h, output int idx);
    longint b, sz;
    b   = longint'(cfg_base[14:0]) << 25;
    sz  = longint'(32'h0200_0000) << cfg_ctrl[3:1];
    h   = (b != 0) && (b + sz <= 64'h1_0000_0000) &&
          (longint'(a) >= b) && (longint'(a) < b + sz);
    idx = int'((longint'(a) - b) >>> 12);
  endfunction

  // behavioural reference model
  int          cd;
  int          m_idx;
  logic [11:0] m_off;
  bit          m_drop;
  int          cq_tag[$];
  logic [27:0] cq_pg[$];
  bit          e_rv, e_re, e_rd, e_rdy;
  logic [39:0] e_pa;
  int          e_ra;

  always @(posedge clk) begin
    if (!rst_n) begin
      cd = 0; m_drop = 0; e_rv = 0; e_re = 0; e_pa = '0; e_rd = 0; e_rdy = 1;
      cq_tag.delete(); cq_pg.delete();
    end else begin
      bit h; int ix; bit found; logic [31:0] e;
      e_rv = 0; e_re = 0; e_pa = '0; e_rd = 0;
      if (flush) begin cq_tag.delete(); cq_pg.delete(); end
      if (cd > 0) begin
        if (flush) m_drop = 1;
        cd--;
        if (cd == 0) begin
          e = tbl_entry(m_idx);
          e_rv = 1;
          if (e[0]) begin
            e_pa = {e[11:4], e[31:12], m_off};
            if (!m_drop) begin
              cq_tag.push_back(m_idx);
              cq_pg.push_back({e[11:4], e[31:12]});
              if (cq_tag.size() > NE) begin
                void'(cq_tag.pop_front()); void'(cq_pg.pop_front());
              end
            end
          end else e_re = 1;
        end
      end else if (req_valid) begin
        win(req_addr, h, ix);
        if (!h) begin e_rv = 1; e_re = 1; end
        else begin
          found = 0;
          foreach (cq_tag[k]) if (cq_tag[k] == ix) begin
            found = 1; e_rv = 1; e_pa = {cq_pg[k], req_addr[11:0]};
          end
          if (!found) begin
            cd = 3; m_idx = ix; m_off = req_addr[11:0]; m_drop = 0;
            e_rd = 1; e_ra = ix;
          end
        end
      end
      e_rdy = (cd == 0);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(rsp_valid == e_rv, "rsp_valid", 64'(rsp_valid), 64'(e_rv));
      if (e_rv) begin
        chk(rsp_err == e_re, "rsp_err", 64'(rsp_err), 64'(e_re));
        chk(rsp_paddr == e_pa, "rsp_paddr", 64'(rsp_paddr), 64'(e_pa));
      end
      chk(tbl_rd_en == e_rd, "tbl_rd_en", 64'(tbl_rd_en), 64'(e_rd));
      if (e_rd) chk(int'(tbl_rd_idx) == e_ra, "tbl_rd_idx", 64'(tbl_rd_idx), 64'(e_ra));
      chk(req_ready == e_rdy, "req_ready", 64'(req_ready), 64'(e_rdy));
    end
  end

  task automatic send(logic [31:0] a, bit fl = 0);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_addr = a; flush = fl;
    @(negedge clk);
    req_valid = 0; flush = 0;
  endtask

  task automatic pulse_flush();
    flush = 1;
    @(negedge clk);
    flush = 0;
  endtask

  task automatic settle();
    while (!req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  localparam logic [31:0] B = 32'h0200_0000;

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; flush = 0; req_valid = 0; req_addr = '0;
    cfg_base = 32'h1; cfg_ctrl = 32'h0;
    repeat (3) @(negedge clk);
    cur = "R1";
    chk(rsp_valid == 0, "reset rsp_valid", 64'(rsp_valid), 0);
    chk(tbl_rd_en == 0, "reset tbl_rd_en", 64'(tbl_rd_en), 0);
    chk(req_ready == 1, "reset req_ready", 64'(req_ready), 1);
    rst_n = 1;
    repeat (4) @(negedge clk);

    cur = "R2";  // first and last page of a 32 MB window at 32 MB
    send(B + 32'h123); send(B + 32'h01FF_FABC); settle();
    cur = "R4";  // just below, just above, zero
    send(B - 1); send(B + 32'h0200_0000); send(32'h0); settle();
    cur = "R8";  // repeats hit
    send(B + 32'hFFF); send(B + 32'h01FF_F000); settle();
    cur = "R7";
    ovr[5] = 32'hABCD_E0F0;
    send(B + 5*4096 + 7); send(B + 5*4096 + 9); settle();
    cur = "R12";
    ovr[6] = 32'h1234_5A7D;
    send(B + 6*4096 + 1); send(B + 6*4096 + 2); settle();
    cur = "R6";
    ovr[9] = 32'hFFFF_FFF1;
    send(B + 9*4096 + 32'hABC); settle();

    cur = "R11";
    pulse_flush();
    for (int p = 20; p < 25; p++) send(B + p*4096);
    send(B + 20*4096); send(B + 24*4096); send(B + 21*4096); send(B + 22*4096);
    settle();

    cur = "R9";
    send(B + 30*4096); settle(); pulse_flush(); send(B + 30*4096); settle();
    send(B + 30*4096 + 4, 1); settle(); send(B + 30*4096 + 8); settle();

    cur = "R10";
    send(B + 40*4096); pulse_flush(); settle(); send(B + 40*4096); settle();
    send(B + 41*4096); @(negedge clk); @(negedge clk); pulse_flush(); settle();
    send(B + 41*4096); settle();

    cur = "R3";
    pulse_flush();
    cfg_base = 32'h0;        send(32'h0000_1000); settle();
    cfg_base = 32'h7F; cfg_ctrl = 32'h2; send(32'hFE00_0000); settle();
    cfg_ctrl = 32'h0; pulse_flush(); send(32'hFFFF_FFFF); send(32'hFE00_0000); settle();
    cfg_base = 32'h1; cfg_ctrl = 32'hE; send(B); settle();
    cfg_base = 32'h4000; cfg_ctrl = 32'h0; send(32'h8000_0000); settle();

    cur = "R2";  // 256 MB window at 128 MB, stray config bits set
    cfg_base = 32'hFFFF_8004; cfg_ctrl = 32'hFFFF_FFF7; pulse_flush();
    send(32'h17FF_F123); send(32'h1800_0000); send(32'h0800_0000); send(32'h07FF_FFFF);
    settle();

    cur = "R5";  // mixed random traffic with flushes
    cfg_base = 32'h1; cfg_ctrl = 32'h0; pulse_flush();
    ovr[7] = 32'h0000_0002;
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      if ($urandom % 10 == 0) a = 32'h0100_0000 + ($urandom % 32'h0100_0000);
      else a = B + ($urandom % 12) * 4096 + ($urandom % 4096);
      send(a, ($urandom % 8) == 0);
      if ($urandom % 5 == 0) pulse_flush();
      repeat ($urandom % 3) @(negedge clk);
    end
    settle();
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule